// File: doc/BRIEF.md
# GCM Authentication Tag Finisher

This block sits at the tail of a GCM datapath. It takes the full 128-bit authentication tag after the last GHASH step and produces the final result. In outbound (encrypt) work it returns the tag cut to the programmed length, together with a byte-enable mask. In inbound (decrypt) work it compares the computed tag with a received tag that software stored in advance. The comparison covers the same number of bytes, and the block reports a one-cycle done pulse with a fail flag.

Software programs the tag length and the received tag through a small write-only register port. The length field accepts any value, but only two short lengths are honoured. Every other value selects the full 16 bytes. A tag that belongs to a saved intermediate context, where the last GHASH iteration has not run, passes through the input handshake and produces no result.

Top module: `gcm_tag_finish`

## Requirements
- R1: After reset, `out_valid`, `chk_done`, `chk_fail`, `out_tag` and `out_bytes_en` are all zero. `in_ready` is 1. The length register reads as 0, which selects 16 bytes, and the stored received tag is all zero.
- R2: The effective tag length is 8 bytes when the length register holds 8 and 12 bytes when it holds 12. Any other value (0, 1 to 7, 9 to 11, 13 to 255) selects 16 bytes, with no truncation.
- R3: When a tag is accepted with `in_final`=1 and `in_inbound`=0, `out_valid` is 1 for exactly the next cycle. In that cycle `out_tag` carries the most significant effective bytes of the input tag, and all lower bytes read zero.
- R4: Bit i of `out_bytes_en` is set when byte i of `out_tag` (bits 8i+7..8i) belongs to the tag. Bit 15 stands for bits 127:120, and the set bits always run from bit 15 downward.
- R5: When a tag is accepted with `in_final`=1 and `in_inbound`=1, `chk_done` is 1 for exactly the next cycle. `chk_fail` is 1 in that cycle if any selected byte of the input differs from the stored received tag, and 0 otherwise.
- R6: Bytes below the effective length have no effect on `chk_fail`, whatever their values in the input or in the stored tag.
- R7: A tag accepted with `in_final`=0 raises neither `out_valid` nor `chk_done`, and it leaves `out_tag` and `out_bytes_en` unchanged.
- R8: A register write with address 0 loads `reg_wdata[7:0]` into the length register. Addresses 1 to 4 load the received tag 32 bits at a time, with address 1 holding bits 127:96 and address 4 holding bits 31:0. Writes to addresses 5 to 7 change nothing.
- R9: `in_ready` stays 1 out of reset, so a new tag can be accepted on every cycle. Each accepted tag produces its own result one cycle later.
- R10: `chk_fail` is never 1 without `chk_done`, and `out_valid` and `chk_done` are never 1 in the same cycle.
- R11: A register write in the same cycle as a tag acceptance affects only later tags. The accepted tag uses the settings held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Computed tag is offered |
| in_ready | output | 1 | Block can accept a tag |
| in_tag | input | 128 | Full computed tag, most significant byte first |
| in_final | input | 1 | 1: last GHASH iteration ran; 0: intermediate context |
| in_inbound | input | 1 | 1: verify against stored tag; 0: emit tag |
| out_valid | output | 1 | Outbound tag valid, one cycle |
| out_tag | output | 128 | Truncated tag, unused bytes zero |
| out_bytes_en | output | 16 | Byte-valid mask of `out_tag` |
| chk_done | output | 1 | Inbound comparison finished, one cycle |
| chk_fail | output | 1 | Inbound tags differ, valid with `chk_done` |

## Verification
On every cycle, the assertions check several cycle-level properties:
- the one-cycle timing from acceptance to `out_valid` or `chk_done`;
- the exclusivity of the two result pulses and the pairing of `chk_fail` with `chk_done`;
- the zero bytes outside the mask, the shape of the mask, and the stability of the output tag when no outbound result is produced.

Only the bench scenarios can show the data-level behaviour:
- how programmed lengths map to effective lengths;
- which bytes are kept;
- the register address map;
- that differences outside the effective length are ignored while a single changed selected byte fails;
- that a write in the same cycle as an acceptance does not reach that tag.

// File: rtl/gcm_tag_pkg.sv
package gcm_tag_pkg;

   // Selected tag length class
   typedef enum logic [1:0] {
      TLEN_SHORT_A = 2'd0,
      TLEN_SHORT_B = 2'd1,
      TLEN_FULL    = 2'd2
   } tag_len_e;

   // Action requested for an accepted tag
   typedef enum logic [1:0] {
      ACT_NONE   = 2'd0,
      ACT_EMIT   = 2'd1,
      ACT_VERIFY = 2'd2
   } tag_act_e;

   function automatic tag_act_e pick_action(input logic fin, input logic inb);
      if (!fin)
         return ACT_NONE;
      return inb ? ACT_VERIFY : ACT_EMIT;
   endfunction

endpackage

// File: rtl/gcm_tag_size_dec.sv
module gcm_tag_size_dec
   import gcm_tag_pkg::*;
#(
   parameter int TAG_BYTES = 16,
   parameter int SIZE_W    = 8,
   parameter int SHORT_A   = 8,
   parameter int SHORT_B   = 12
) (
   input  logic [SIZE_W-1:0]    size_raw,
   output tag_len_e             len_cls,
   output logic [TAG_BYTES-1:0] byte_mask
);

   localparam int KEEP_A = TAG_BYTES - SHORT_A;
   localparam int KEEP_B = TAG_BYTES - SHORT_B;

   if (SHORT_A <= 0 || SHORT_A >= TAG_BYTES) begin : g_bad_a
      $error("SHORT_A must lie strictly between 0 and TAG_BYTES");
   end
   if (SHORT_B <= 0 || SHORT_B >= TAG_BYTES || SHORT_B == SHORT_A) begin : g_bad_b
      $error("SHORT_B must be a distinct length below TAG_BYTES");
   end
   if ((1 << SIZE_W) <= TAG_BYTES) begin : g_bad_w
      $error("SIZE_W too narrow for TAG_BYTES");
   end

   always_comb begin
      if (size_raw == SIZE_W'(SHORT_A))
         len_cls = TLEN_SHORT_A;
      else if (size_raw == SIZE_W'(SHORT_B))
         len_cls = TLEN_SHORT_B;
      else
         len_cls = TLEN_FULL;
   end

   for (genvar i = 0; i < TAG_BYTES; i++) begin : g_mask
      always_comb begin
         unique case (len_cls)
            TLEN_SHORT_A: byte_mask[i] = (i >= KEEP_A);
            TLEN_SHORT_B: byte_mask[i] = (i >= KEEP_B);
            default:      byte_mask[i] = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/gcm_tag_regs.sv
module gcm_tag_regs #(
   parameter int TAG_BYTES = 16,
   parameter int SIZE_W    = 8,
   parameter int ADDR_W    = 3,
   parameter int DATA_W    = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_wr,
   input  logic [ADDR_W-1:0]      reg_addr,
   input  logic [DATA_W-1:0]      reg_wdata,
   output logic [SIZE_W-1:0]      size_raw,
   output logic [TAG_BYTES*8-1:0] rx_tag
);

   localparam int TAG_W = TAG_BYTES * 8;
   localparam int WORDS = TAG_W / DATA_W;

   if (TAG_W % DATA_W != 0) begin : g_bad_div
      $error("tag width must be a multiple of DATA_W");
   end
   if (SIZE_W > DATA_W) begin : g_bad_size
      $error("SIZE_W wider than the write bus");
   end
   if ((1 << ADDR_W) <= WORDS) begin : g_bad_addr
      $error("ADDR_W cannot reach every tag word");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         size_raw <= '0;
      else if (reg_wr && reg_addr == '0)
         size_raw <= reg_wdata[SIZE_W-1:0];
   end

   // Word k (address k+1) covers the k-th slice counted from the top
   for (genvar k = 0; k < WORDS; k++) begin : g_word
      localparam int HI = TAG_W - 1 - k * DATA_W;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rx_tag[HI -: DATA_W] <= '0;
         else if (reg_wr && reg_addr == ADDR_W'(k + 1))
            rx_tag[HI -: DATA_W] <= reg_wdata;
      end
   end

endmodule

// File: rtl/gcm_tag_engine.sv
module gcm_tag_engine #(
   parameter int TAG_BYTES = 16
) (
   input  logic [TAG_BYTES*8-1:0] tag_in,
   input  logic [TAG_BYTES*8-1:0] rx_tag,
   input  logic [TAG_BYTES-1:0]   byte_mask,
   output logic [TAG_BYTES*8-1:0] tag_cut,
   output logic                   mismatch
);

   logic [TAG_BYTES-1:0] byte_diff;

   // Every byte is compared in parallel; the verdict is a plain OR over all lanes
   for (genvar i = 0; i < TAG_BYTES; i++) begin : g_lane
      assign tag_cut[8*i +: 8] = byte_mask[i] ? tag_in[8*i +: 8] : 8'h00;
      assign byte_diff[i]      = byte_mask[i] & (|(tag_in[8*i +: 8] ^ rx_tag[8*i +: 8]));
   end

   assign mismatch = |byte_diff;

endmodule

// File: rtl/gcm_tag_finish.sv
module gcm_tag_finish
   import gcm_tag_pkg::*;
#(
   parameter int TAG_BYTES = 16,
   parameter int SIZE_W    = 8,
   parameter int SHORT_A   = 8,
   parameter int SHORT_B   = 12,
   parameter int ADDR_W    = 3,
   parameter int DATA_W    = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_wr,
   input  logic [ADDR_W-1:0]      reg_addr,
   input  logic [DATA_W-1:0]      reg_wdata,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [TAG_BYTES*8-1:0] in_tag,
   input  logic                   in_final,
   input  logic                   in_inbound,
   output logic                   out_valid,
   output logic [TAG_BYTES*8-1:0] out_tag,
   output logic [TAG_BYTES-1:0]   out_bytes_en,
   output logic                   chk_done,
   output logic                   chk_fail
);

   localparam int TAG_W = TAG_BYTES * 8;

   logic [SIZE_W-1:0]    size_raw;
   logic [TAG_W-1:0]     rx_tag;
   tag_len_e             len_cls;
   logic [TAG_BYTES-1:0] byte_mask;
   logic [TAG_W-1:0]     tag_cut;
   logic                 mismatch;
   logic                 ready_q;
   logic                 accept;
   tag_act_e             act;

   gcm_tag_regs #(
      .TAG_BYTES(TAG_BYTES), .SIZE_W(SIZE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .size_raw(size_raw), .rx_tag(rx_tag)
   );

   gcm_tag_size_dec #(
      .TAG_BYTES(TAG_BYTES), .SIZE_W(SIZE_W), .SHORT_A(SHORT_A), .SHORT_B(SHORT_B)
   ) u_dec (
      .size_raw(size_raw), .len_cls(len_cls), .byte_mask(byte_mask)
   );

   gcm_tag_engine #(
      .TAG_BYTES(TAG_BYTES)
   ) u_eng (
      .tag_in(in_tag), .rx_tag(rx_tag), .byte_mask(byte_mask),
      .tag_cut(tag_cut), .mismatch(mismatch)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ready_q <= 1'b0;
      else        ready_q <= 1'b1;
   end

   assign in_ready = ready_q;
   assign accept   = in_valid & ready_q;
   assign act      = accept ? pick_action(in_final, in_inbound) : ACT_NONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         chk_done     <= 1'b0;
         chk_fail     <= 1'b0;
         out_tag      <= '0;
         out_bytes_en <= '0;
      end else begin
         out_valid <= (act == ACT_EMIT);
         chk_done  <= (act == ACT_VERIFY);
         chk_fail  <= (act == ACT_VERIFY) & mismatch;
         if (act == ACT_EMIT) begin
            out_tag      <= tag_cut;
            out_bytes_en <= byte_mask;
         end
      end
   end

endmodule

// File: rtl/gcm_tag_finish_chk.sv
module gcm_tag_finish_chk #(
   parameter int TAG_BYTES = 16,
   parameter int SHORT_A   = 8,
   parameter int SHORT_B   = 12
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic                   in_ready,
   input logic                   in_final,
   input logic                   in_inbound,
   input logic                   out_valid,
   input logic [TAG_BYTES*8-1:0] out_tag,
   input logic [TAG_BYTES-1:0]   out_bytes_en,
   input logic                   chk_done,
   input logic                   chk_fail
);

   logic [TAG_BYTES*8-1:0] en_bits;
   always_comb begin
      for (int i = 0; i < TAG_BYTES; i++)
         en_bits[8*i +: 8] = {8{out_bytes_en[i]}};
   end

   logic go;
   assign go = in_valid && in_ready && in_final;

   AST_FAIL_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      chk_fail |-> chk_done); // R10
   AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_valid && chk_done)); // R10
   AST_EMIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !in_inbound) |=> out_valid); // R3
   AST_VERIFY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (go && in_inbound) |=> chk_done); // R5
   AST_PARTIAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !in_final) |=> (!out_valid && !chk_done)); // R7
   AST_TAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(go && !in_inbound) |=> ($stable(out_tag) && $stable(out_bytes_en))); // R7
   AST_ZERO_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_tag & ~en_bits) == '0)); // R3
   AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_bytes_en[TAG_BYTES-1] &&
                     ($countones(out_bytes_en) == SHORT_A ||
                      $countones(out_bytes_en) == SHORT_B ||
                      $countones(out_bytes_en) == TAG_BYTES))); // R4
   AST_READY_UP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> in_ready); // R9

endmodule

bind gcm_tag_finish gcm_tag_finish_chk #(
   .TAG_BYTES(TAG_BYTES), .SHORT_A(SHORT_A), .SHORT_B(SHORT_B)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .in_final(in_final), .in_inbound(in_inbound), .out_valid(out_valid),
   .out_tag(out_tag), .out_bytes_en(out_bytes_en), .chk_done(chk_done),
   .chk_fail(chk_fail)
);

// File: tb/sim_gcm_tag_finish.sv
module sim_gcm_tag_finish;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_wr = 1'b0;
   logic [2:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [127:0] in_tag = '0;
   logic         in_final = 1'b0;
   logic         in_inbound = 1'b0;
   logic         out_valid;
   logic [127:0] out_tag;
   logic [15:0]  out_bytes_en;
   logic         chk_done;
   logic         chk_fail;

   int checks = 0;
   int errors = 0;

   // bench model state
   logic [7:0]   m_size = 8'd0;
   logic [127:0] m_rx = '0;
   logic [127:0] m_out = '0;
   logic [15:0]  m_en = '0;

   always #4 clk = ~clk;

   gcm_tag_finish u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .in_valid(in_valid), .in_ready(in_ready),
      .in_tag(in_tag), .in_final(in_final), .in_inbound(in_inbound),
      .out_valid(out_valid), .out_tag(out_tag), .out_bytes_en(out_bytes_en),
      .chk_done(chk_done), .chk_fail(chk_fail)
   );

   function automatic int eff_len(input logic [7:0] s);
      if (s == 8'd8)  return 8;
      if (s == 8'd12) return 12;
      return 16;
   endfunction

   function automatic logic [15:0] mask_of(input logic [7:0] s);
      logic [15:0] m;
      for (int i = 0; i < 16; i++) m[i] = (i >= 16 - eff_len(s));
      return m;
   endfunction

   function automatic logic [127:0] expand(input logic [15:0] m);
      logic [127:0] e;
      for (int i = 0; i < 16; i++) e[8*i +: 8] = {8{m[i]}};
      return e;
   endfunction

   task automatic check(input bit ok, input string req, input logic [127:0] act,
                        input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      if (a == 3'd0) m_size = d[7:0];
      else if (a <= 3'd4) m_rx[127 - 32*(a-1) -: 32] = d;
   endtask

   task automatic load_rx(input logic [127:0] t);
      for (int k = 0; k < 4; k++) wr(3'(k + 1), t[127 - 32*k -: 32]);
   endtask

   // compare outputs against the model for one accepted tag
   task automatic expect_res(input logic fin, input logic inb, input logic [127:0] t,
                             input logic [7:0] sz, input string req);
      logic [15:0] m;
      logic        f;
      m = mask_of(sz);
      f = |((t ^ m_rx) & expand(m));
      if (fin && !inb) begin m_out = t & expand(m); m_en = m; end
      check(out_valid == (fin && !inb), req, 128'(out_valid), 128'(fin && !inb));
      check(chk_done == (fin && inb), req, 128'(chk_done), 128'(fin && inb));
      check(chk_fail == (fin && inb && f), req, 128'(chk_fail), 128'(fin && inb && f));
      check(out_tag == m_out, req, out_tag, m_out);
      check(out_bytes_en == m_en, req, 128'(out_bytes_en), 128'(m_en));
   endtask

   task automatic send(input logic [127:0] t, input logic fin, input logic inb,
                       input string req);
      @(negedge clk);
      in_valid = 1'b1; in_tag = t; in_final = fin; in_inbound = inb;
      @(negedge clk);
      in_valid = 1'b0;
      expect_res(fin, inb, t, m_size, req);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [127:0] a, b, noise;
      logic [7:0]   sz;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(!out_valid && !chk_done && !chk_fail, "R1", 128'({out_valid, chk_done, chk_fail}), 128'd0);
      check(out_tag == '0 && out_bytes_en == '0, "R1", out_tag, 128'd0);
      check(in_ready, "R1 R9", 128'(in_ready), 128'd1);
      // R1: reset length behaves as 16, stored tag zero
      send(128'h0, 1'b1, 1'b1, "R1 zero stored tag");
      a = 128'h0123456789ABCDEF_FEDCBA9876543210;
      send(a, 1'b1, 1'b0, "R1 R2 default full length");

      // R2 R3 R4 directed lengths
      wr(3'd0, 32'd8);  send(a, 1'b1, 1'b0, "R2 R3 R4 length 8");
      wr(3'd0, 32'd12); send(a, 1'b1, 1'b0, "R2 R3 R4 length 12");
      wr(3'd0, 32'd1);  send(a, 1'b1, 1'b0, "R2 length 1 as 16");
      wr(3'd0, 32'd16); send(a, 1'b1, 1'b0, "R2 length 16");
      wr(3'd0, 32'd9);  send(a, 1'b1, 1'b0, "R2 length 9 as 16");
      wr(3'd0, 32'd200); send(a, 1'b1, 1'b0, "R2 length 200 as 16");
      wr(3'd0, 32'h0000_0108); send(a, 1'b1, 1'b0, "R8 low byte only, 8");

      // R8 map and R5 R6 verify
      load_rx(a);
      send(a, 1'b1, 1'b1, "R5 R8 equal tags pass");
      wr(3'd5, 32'hFFFF_FFFF); wr(3'd7, 32'h1234_5678);
      send(a, 1'b1, 1'b1, "R8 unused addresses ignored");
      send(a ^ 128'h00FF, 1'b1, 1'b1, "R6 low byte differs, length 8");
      send(a ^ (128'h01 << 64), 1'b1, 1'b1, "R5 byte 8 differs, length 8");
      wr(3'd0, 32'd12);
      send(a ^ (128'h80 << 32), 1'b1, 1'b1, "R5 byte 4 differs, length 12");
      send(a ^ 128'hFFFF_FFFF, 1'b1, 1'b1, "R6 low word ignored, length 12");
      wr(3'd4, 32'h0); // stored tag changes only in ignored bytes
      send(a, 1'b1, 1'b1, "R6 R8 stored low word ignored");

      // R7 partial context
      send(~a, 1'b0, 1'b0, "R7 partial outbound");
      send(~a, 1'b0, 1'b1, "R7 partial inbound");

      // R9 back to back
      @(negedge clk);
      in_valid = 1'b1; in_tag = ~a; in_final = 1'b1; in_inbound = 1'b0;
      @(negedge clk);
      expect_res(1'b1, 1'b0, ~a, m_size, "R9 first of pair");
      in_tag = a; in_inbound = 1'b1;
      @(negedge clk);
      expect_res(1'b1, 1'b1, a, m_size, "R9 second of pair");
      in_valid = 1'b0;

      // R11 write during acceptance
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'd8;
      in_valid = 1'b1; in_tag = b; in_tag = a; in_final = 1'b1; in_inbound = 1'b0;
      @(negedge clk);
      reg_wr = 1'b0; in_valid = 1'b0;
      expect_res(1'b1, 1'b0, a, 8'd12, "R11 old length used");
      m_size = 8'd8;
      send(a, 1'b1, 1'b0, "R11 new length afterwards");

      // constrained random
      for (int n = 0; n < 300; n++) begin
         case ($urandom_range(0, 3))
            0: sz = 8'd8;
            1: sz = 8'd12;
            2: sz = 8'($urandom_range(0, 17));
            default: sz = 8'($urandom);
         endcase
         wr(3'd0, {$urandom, 8'(sz)} >> 8 << 8 | 32'(sz));
         b = {$urandom, $urandom, $urandom, $urandom};
         load_rx(b);
         noise = {$urandom, $urandom, $urandom, $urandom};
         send(noise, 1'b1, 1'b0, "R3 R4 random emit");
         a = b ^ (noise & ~expand(mask_of(m_size)));
         send(a, 1'b1, 1'b1, "R6 random outside noise");
         a[8*(15 - $urandom_range(0, eff_len(m_size) - 1)) +: 8] ^= 8'($urandom_range(1, 255));
         send(a, 1'b1, 1'b1, "R5 random selected byte");
         send(noise, $urandom_range(0, 3) != 0 ? 1'b1 : 1'b0, 1'($urandom), "R7 R10 random mix");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule